// File: doc/BRIEF.md
# A/D Conversion Phase Timer

This block sets the pace of a successive-approximation A/D converter. From the system clock it makes a conversion-clock enable at one of eight divide ratios, two of which (/6 and /5) are not powers of two. It then steps each conversion through a fixed series of phases: a settle phase on the first conversion only, a sampling window, one compare strobe per result bit from the most significant bit down, and a short tail before a one-cycle done pulse. The length of the sampling window and of the whole conversion depends on a two-bit operating mode. A resolution select trims two result bits from the compare phase.

The ratio, mode, resolution and continuous-run settings live in a small configuration register. A write to it takes effect only while both the start request and the converter enable are low. A conversion begins when start and enable become high together, and it is cut short at once when either one drops. In continuous operation a new conversion follows every done pulse without a settle phase. In one-shot operation the sequencer goes back to idle after the done pulse and waits for a new rising request.

Top module: `adc_seq_timer`

## Requirements
- R1: The ratio field selects the system clocks per conversion-clock tick. Code 0 gives 64, 1 gives 32, 2 gives 16, 3 gives 8, 4 gives 6, 5 gives 5, 6 gives 4 and 7 gives 2. `fad_tick_o` pulses for one system clock, once per ratio period, and only while busy.
- R2: Mode code 01 selects the short mode: 17 ticks per conversion at 10-bit resolution, 5 of them sampling (`sample_o` high).
- R3: Mode code 00 selects the long mode: 19 ticks per conversion at 10-bit resolution, 7 of them sampling.
- R4: With `cfg_res8_i` = 1 latched, a conversion has 2 fewer ticks and issues 8 compare strobes instead of 10.
- R5: A configuration write (`cfg_we_i` high) updates the latched settings, seen on `cfg_ratio_o` and `cfg_mode_o` one clock later, only when `start_i` and `conv_en_i` are both 0. Otherwise it is ignored.
- R6: A conversion launched from idle has SETTLE_CYC extra ticks (default 2) before sampling. A back-to-back continuous conversion has none. In system clocks, launch to done takes ratio × (SETTLE_CYC + ticks), and done to done takes ratio × ticks.
- R7: After sampling, `cmp_stb_o` pulses once per result bit, each time together with `fad_tick_o`. `cmp_idx_o` counts down from the top bit index (9, or 7 at 8-bit) to 0.
- R8: `done_o` is high for exactly one system clock. In one-shot mode the sequencer is then idle and does not start again until start and enable go low and then high again.
- R9: Mode codes 10 and 11 time exactly like mode 00.
- R10: When `start_i` or `conv_en_i` is low at a clock edge, `busy_o` is low after that edge, and no done pulse follows.
- R11: After reset the sequencer is idle with all strobes low, and the latched ratio and mode are 0.
- R12: With `cfg_cont_i` = 1 latched, the next conversion begins in the same cycle that `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ratio_i | input | 3 | Conversion-clock ratio code |
| cfg_mode_i | input | 2 | Operating mode code |
| cfg_res8_i | input | 1 | 1 = 8-bit result, 0 = 10-bit result |
| cfg_cont_i | input | 1 | 1 = continuous conversions |
| start_i | input | 1 | Conversion start request (level) |
| conv_en_i | input | 1 | Converter enable (level) |
| fad_tick_o | output | 1 | Conversion-clock enable pulse |
| sample_o | output | 1 | High during the sampling window |
| cmp_stb_o | output | 1 | Per-bit compare strobe |
| cmp_idx_o | output | IDX_W (4) | Bit index of the current compare strobe |
| done_o | output | 1 | Conversion-complete pulse |
| busy_o | output | 1 | Conversion in progress |
| cfg_ratio_o | output | 3 | Latched ratio code |
| cfg_mode_o | output | 2 | Latched mode code |

## Verification
The bench builds the block with its default parameters: a settle phase of two ticks, cycle counts of 19/7 and 17/5, and 10 or 8 result bits. With these values the slowest ratio takes 1344 system clocks, so the bench can run all eight ratio codes in the long mode and compare each launch-to-done time with ratio × 21. The /5 and /6 codes, the short mode, both reserved codes and 8-bit resolution are also measured. Continuous runs show the settle phase being left out, and a mid-conversion abort followed by a relaunch shows it coming back.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DIV_W = 7;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETTLE = 3'd1,
        PH_SAMP   = 3'd2,
        PH_BITS   = 3'd3,
        PH_TAIL   = 3'd4
    } phase_e;

    typedef struct packed {
        logic [2:0] ratio;
        logic [1:0] mode;
        logic       res8;
        logic       cont;
    } seq_cfg_t;

    // System clocks per conversion-clock tick for each ratio code.
    function automatic logic [DIV_W-1:0] ratio_div(input logic [2:0] sel);
        logic [DIV_W-1:0] r;
        case (sel)
            3'd0:    r = DIV_W'(64);
            3'd1:    r = DIV_W'(32);
            3'd2:    r = DIV_W'(16);
            3'd3:    r = DIV_W'(8);
            3'd4:    r = DIV_W'(6);
            3'd5:    r = DIV_W'(5);
            3'd6:    r = DIV_W'(4);
            default: r = DIV_W'(2);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/adc_cfg_lock.sv
module adc_cfg_lock
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  logic     start,
    input  logic     enable,
    input  seq_cfg_t wr_cfg,
    output seq_cfg_t cfg
);

    seq_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        // The settings may only change while the converter is fully stopped.
        if (we && !start && !enable) begin
            cfg_d = wr_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/adc_fad_div.sv
module adc_fad_div
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    term;

    assign term = (st_q.cnt == div - DIV_W'(1));

    always_comb begin
        st_d = st_q;
        if (!run || term) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = run && term;

endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
    import adc_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 2,
    parameter int SAMP_N1    = 7,
    parameter int TOTAL_N1   = 19,
    parameter int SAMP_N2    = 5,
    parameter int TOTAL_N2   = 17,
    parameter int RES_HI     = 10,
    parameter int RES_LO     = 8,
    parameter int PH_W       = 5,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic             res8,
    input  logic             cont,
    output logic             busy,
    output logic             sample,
    output logic             cmp_stb,
    output logic [IDX_W-1:0] cmp_idx,
    output logic             done
);

    typedef struct packed {
        phase_e          ph;
        logic [PH_W-1:0] cnt;
        logic            go_q;
        logic            done;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    int samp_len;
    int tot_len;
    int nbits;
    int tail_len;
    int cur_len;
    int idx_val;
    logic last;

    always_comb begin
        // Codes 10 and 11 are reserved and fall back to the long mode.
        samp_len = (mode == 2'b01) ? SAMP_N2 : SAMP_N1;
        tot_len  = (mode == 2'b01) ? TOTAL_N2 : TOTAL_N1;
        nbits    = res8 ? RES_LO : RES_HI;
        tail_len = tot_len - samp_len - RES_HI;
        case (st_q.ph)
            PH_SETTLE: cur_len = SETTLE_CYC;
            PH_SAMP:   cur_len = samp_len;
            PH_BITS:   cur_len = nbits;
            PH_TAIL:   cur_len = tail_len;
            default:   cur_len = 1;
        endcase
        last = (int'(st_q.cnt) == cur_len - 1);
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.go_q = go;
        if (!go) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else begin
            case (st_q.ph)
                PH_IDLE: begin
                    if (!st_q.go_q) begin
                        st_d.ph  = (SETTLE_CYC > 0) ? PH_SETTLE : PH_SAMP;
                        st_d.cnt = '0;
                    end
                end
                default: begin
                    if (tick) begin
                        if (last) begin
                            st_d.cnt = '0;
                            case (st_q.ph)
                                PH_SETTLE: st_d.ph = PH_SAMP;
                                PH_SAMP:   st_d.ph = PH_BITS;
                                PH_BITS:   st_d.ph = PH_TAIL;
                                default: begin
                                    st_d.done = 1'b1;
                                    st_d.ph   = cont ? PH_SAMP : PH_IDLE;
                                end
                            endcase
                        end else begin
                            st_d.cnt = st_q.cnt + PH_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.cnt  <= '0;
            st_q.go_q <= 1'b0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        idx_val = nbits - 1 - int'(st_q.cnt);
        busy    = (st_q.ph != PH_IDLE);
        sample  = (st_q.ph == PH_SAMP);
        cmp_stb = (st_q.ph == PH_BITS) && tick;
        cmp_idx = (st_q.ph == PH_BITS) ? IDX_W'(idx_val) : '0;
        done    = st_q.done;
    end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
    import adc_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 2,
    parameter int SAMP_N1    = 7,
    parameter int TOTAL_N1   = 19,
    parameter int SAMP_N2    = 5,
    parameter int TOTAL_N2   = 17,
    parameter int RES_HI     = 10,
    parameter int RES_LO     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we_i,
    input  logic [2:0]                cfg_ratio_i,
    input  logic [1:0]                cfg_mode_i,
    input  logic                      cfg_res8_i,
    input  logic                      cfg_cont_i,
    input  logic                      start_i,
    input  logic                      conv_en_i,
    output logic                      fad_tick_o,
    output logic                      sample_o,
    output logic                      cmp_stb_o,
    output logic [$clog2(RES_HI)-1:0] cmp_idx_o,
    output logic                      done_o,
    output logic                      busy_o,
    output logic [2:0]                cfg_ratio_o,
    output logic [1:0]                cfg_mode_o
);

    localparam int IDX_W = $clog2(RES_HI);
    localparam int PH_W  = $clog2(TOTAL_N1 + SETTLE_CYC + 1);

    seq_cfg_t         wr_cfg;
    seq_cfg_t         cfg;
    logic             cfg_cont;
    logic             go;
    logic [DIV_W-1:0] div;

    assign wr_cfg = '{ratio: cfg_ratio_i, mode: cfg_mode_i,
                      res8: cfg_res8_i, cont: cfg_cont_i};
    assign go       = start_i && conv_en_i;
    assign div      = ratio_div(cfg.ratio);
    assign cfg_cont = cfg.cont;

    adc_cfg_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we_i),
        .start  (start_i),
        .enable (conv_en_i),
        .wr_cfg (wr_cfg),
        .cfg    (cfg)
    );

    adc_fad_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_o),
        .div   (div),
        .tick  (fad_tick_o)
    );

    adc_phase_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .SAMP_N1    (SAMP_N1),
        .TOTAL_N1   (TOTAL_N1),
        .SAMP_N2    (SAMP_N2),
        .TOTAL_N2   (TOTAL_N2),
        .RES_HI     (RES_HI),
        .RES_LO     (RES_LO),
        .PH_W       (PH_W),
        .IDX_W      (IDX_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .tick    (fad_tick_o),
        .mode    (cfg.mode),
        .res8    (cfg.res8),
        .cont    (cfg.cont),
        .busy    (busy_o),
        .sample  (sample_o),
        .cmp_stb (cmp_stb_o),
        .cmp_idx (cmp_idx_o),
        .done    (done_o)
    );

    assign cfg_ratio_o = cfg.ratio;
    assign cfg_mode_o  = cfg.mode;

endmodule

// File: rtl/adc_seq_timer_chk.sv
module adc_seq_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       conv_en_i,
    input logic       fad_tick_o,
    input logic       sample_o,
    input logic       cmp_stb_o,
    input logic       done_o,
    input logic       busy_o,
    input logic [2:0] cfg_ratio_o,
    input logic [1:0] cfg_mode_o,
    input logic       cfg_cont
);

    a_r1_tick_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fad_tick_o |-> busy_o);

    a_r3_sample_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (busy_o && !cmp_stb_o));

    a_r7_stb_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_stb_o |-> fad_tick_o);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_oneshot_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cfg_cont) |-> !busy_o);

    a_r12_cont_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cfg_cont && start_i && conv_en_i) |-> busy_o);

    a_r5_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || conv_en_i) |=> ($stable(cfg_ratio_o) && $stable(cfg_mode_o)));

    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && conv_en_i) |=> (!busy_o && !done_o));

endmodule

bind adc_seq_timer adc_seq_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .conv_en_i   (conv_en_i),
    .fad_tick_o  (fad_tick_o),
    .sample_o    (sample_o),
    .cmp_stb_o   (cmp_stb_o),
    .done_o      (done_o),
    .busy_o      (busy_o),
    .cfg_ratio_o (cfg_ratio_o),
    .cfg_mode_o  (cfg_mode_o),
    .cfg_cont    (cfg_cont)
);

// File: tb/adc_seq_timer_bench.sv
`timescale 1ns/1ps
module adc_seq_timer_bench;

    localparam int SETTLE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [2:0] cfg_ratio_i = '0;
    logic [1:0] cfg_mode_i = '0;
    logic       cfg_res8_i = 1'b0;
    logic       cfg_cont_i = 1'b0;
    logic       start_i = 1'b0;
    logic       conv_en_i = 1'b0;
    logic       fad_tick_o, sample_o, cmp_stb_o, done_o, busy_o;
    logic [3:0] cmp_idx_o;
    logic [2:0] cfg_ratio_o;
    logic [1:0] cfg_mode_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_seq_timer u_adc_seq_timer (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_ratio_i(cfg_ratio_i),
        .cfg_mode_i(cfg_mode_i), .cfg_res8_i(cfg_res8_i), .cfg_cont_i(cfg_cont_i),
        .start_i(start_i), .conv_en_i(conv_en_i), .fad_tick_o(fad_tick_o),
        .sample_o(sample_o), .cmp_stb_o(cmp_stb_o), .cmp_idx_o(cmp_idx_o),
        .done_o(done_o), .busy_o(busy_o), .cfg_ratio_o(cfg_ratio_o),
        .cfg_mode_o(cfg_mode_o)
    );

    function automatic int div_of(input int code);
        case (code)
            0: return 64; 1: return 32; 2: return 16; 3: return 8;
            4: return 6;  5: return 5;  6: return 4;  default: return 2;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int ratio, input int mode, input bit r8, input bit cont);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_ratio_i = 3'(ratio); cfg_mode_i = 2'(mode);
        cfg_res8_i = r8; cfg_cont_i = cont;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    // Raises start and enable, then counts negedges up to and including done.
    task automatic launch_measure(input int nbits, output int cyc, output int samp,
                                  output int ticks, output int stb);
        @(negedge clk);
        start_i = 1'b1; conv_en_i = 1'b1;
        cyc = 0; samp = 0; ticks = 0; stb = 0;
        while (cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (sample_o) samp++;
            if (fad_tick_o) ticks++;
            if (cmp_stb_o) begin
                check(int'(cmp_idx_o) == nbits - 1 - stb, "R7 compare index order",
                      int'(cmp_idx_o), nbits - 1 - stb);
                stb++;
            end
            if (done_o) break;
        end
    endtask

    task automatic stop_conv();
        @(negedge clk);
        start_i = 1'b0; conv_en_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check(!busy_o && !done_o && !sample_o && !cmp_stb_o && !fad_tick_o,
              "R11 idle after reset", int'(busy_o), 0);
        check(cfg_ratio_o == 3'd0 && cfg_mode_o == 2'd0, "R11 config cleared",
              int'(cfg_ratio_o), 0);
    endtask

    task automatic t_cfg_lock();
        cfg_write(3, 1, 0, 0);
        check(cfg_ratio_o == 3'd3 && cfg_mode_o == 2'd1, "R5 write while stopped",
              int'(cfg_ratio_o), 3);
        @(negedge clk); conv_en_i = 1'b1;
        cfg_write(5, 0, 0, 0);
        check(cfg_ratio_o == 3'd3 && cfg_mode_o == 2'd1, "R5 ignored with enable",
              int'(cfg_ratio_o), 3);
        @(negedge clk); conv_en_i = 1'b0; start_i = 1'b1;
        cfg_write(6, 2, 0, 0);
        check(cfg_ratio_o == 3'd3 && cfg_mode_o == 2'd1, "R5 ignored with start",
              int'(cfg_ratio_o), 3);
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic t_one(input int ratio, input int mode, input bit r8, input string req);
        int cyc, samp, ticks, stb, tot, sn, nb, d;
        tot = (mode == 1) ? 17 : 19;
        sn  = (mode == 1) ? 5 : 7;
        if (r8) tot -= 2;
        nb  = r8 ? 8 : 10;
        d   = div_of(ratio);
        cfg_write(ratio, mode, r8, 0);
        launch_measure(nb, cyc, samp, ticks, stb);
        check(cyc == d * (SETTLE + tot) + 1, {req, " R1 R6 launch to done"}, cyc,
              d * (SETTLE + tot) + 1);
        check(ticks == SETTLE + tot, {req, " tick count"}, ticks, SETTLE + tot);
        check(samp == sn * d, {req, " sampling window"}, samp, sn * d);
        check(stb == nb, {req, " R7 R4 strobe count"}, stb, nb);
        // R8: request still high, one-shot must stay idle with no new done.
        repeat (3 * d + 5) begin
            @(negedge clk);
            check(!busy_o && !done_o, "R8 no relaunch while held", int'(busy_o), 0);
        end
        stop_conv();
    endtask

    task automatic t_cont();
        int cyc, samp, ticks, stb, n;
        cfg_write(7, 0, 0, 1);
        launch_measure(10, cyc, samp, ticks, stb);
        check(cyc == 2 * 21 + 1, "R6 first continuous conversion", cyc, 43);
        check(busy_o && sample_o, "R12 restart in done cycle", int'(busy_o), 1);
        n = 0;
        while (n < 500) begin
            @(negedge clk); n++;
            if (done_o) break;
        end
        check(n == 2 * 19, "R6 R12 back-to-back without settle", n, 38);
        @(negedge clk);
        check(!done_o, "R8 done lasts one clock", int'(done_o), 0);
        stop_conv();
    endtask

    task automatic t_abort();
        int cyc, samp, ticks, stb, seen;
        cfg_write(3, 0, 0, 0);
        @(negedge clk); start_i = 1'b1; conv_en_i = 1'b1;
        repeat (40) @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check(!busy_o, "R10 abort on start low", int'(busy_o), 0);
        seen = 0;
        repeat (250) begin
            @(negedge clk);
            if (done_o || busy_o) seen++;
        end
        check(seen == 0, "R10 no done after abort", seen, 0);
        conv_en_i = 1'b0;
        launch_measure(10, cyc, samp, ticks, stb);
        check(cyc == 8 * 21 + 1, "R6 settle back after abort", cyc, 169);
        stop_conv();
        cfg_write(4, 0, 0, 0);
        @(negedge clk); start_i = 1'b1; conv_en_i = 1'b1;
        repeat (30) @(negedge clk);
        conv_en_i = 1'b0;
        @(negedge clk);
        check(!busy_o, "R10 abort on enable low", int'(busy_o), 0);
        stop_conv();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_lock();
        for (int r = 0; r < 8; r++) t_one(r, 0, 0, "R3 long mode");
        t_one(5, 1, 0, "R2 short mode /5");
        t_one(4, 1, 0, "R2 short mode /6");
        t_one(2, 0, 1, "R4 long 8-bit");
        t_one(6, 1, 1, "R4 short 8-bit");
        t_one(6, 2, 0, "R9 reserved 10");
        t_one(7, 3, 1, "R9 reserved 11");
        t_cont();
        t_abort();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule